// File: doc/BRIEF.md
# Reloading PWM Down-Counter Timer

This block is a down-counting timer that produces a PWM waveform with an arbitrary duty cycle. The counter decrements once per cycle in which the instruction-clock enable `tick` is high, as long as the run bit is set. When the counter is at zero on a counting tick, an underflow occurs. The counter then loads the value held in the reload register instead of wrapping. If the toggle mode is selected, the PWM pin also inverts at that moment.

Software drives it through a write-only register port. Before starting, it writes the first phase length into the counter, the second phase length into the reload register, and the starting pin level into the output latch. It then sets the run bit. Every underflow sets a pending flag, and each output edge therefore produces an interrupt. In the service routine, software writes the next phase length into the reload register and clears the flag. Alternating the reload value between the on time and the off time gives any duty cycle. The CPU interrupt request is the pending flag masked by the timer enable bit and by a global enable input.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the counter, reload register, control register, pending flag and output latch are all zero, so `pwm_out` and `irq` read 0.
- R2: With run set, the counter decrements on each tick. A tick that finds it at zero is an underflow, which loads the reload value. A phase started from a counter value N therefore lasts N+1 ticks, and each later phase lasts reload+1 ticks.
- R3: While run (control bit 0) is clear, ticks leave the counter unchanged, cause no underflow and set no pending flag.
- R4: Cycles with `tick` low never advance the counter, whether or not run is set.
- R5: The mode field is control bits [3:1]. Only the value 3'b101 makes `pwm_out` invert at each underflow. With any other value, `pwm_out` holds its level.
- R6: A write to address 4 loads `wr_data[0]` into the output latch, and `pwm_out` shows the new level from the next cycle.
- R7: Every underflow sets the pending flag, whatever the mode and enable bits are.
- R8: `irq` is high exactly when the pending flag, the timer enable (control bit 4) and the input `gie` are all 1.
- R9: Only a write to address 3 with `wr_data[0]`=1 clears the pending flag. An underflow in the same cycle keeps the flag set. Writing the control register, including setting the enable bit, never clears it.
- R10: A write to the reload register (address 1) does not change the running phase. It only takes effect at the next underflow.
- R11: A counter write (address 0) in a cycle that would also decrement or underflow takes priority. The counter takes the written value, and that cycle produces no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-clock count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 counter, 1 reload, 2 control, 3 pending clear, 4 output latch |
| wr_data | input | CNT_W | Write data (control: bit0 run, bits[3:1] mode, bit4 interrupt enable) |
| gie | input | 1 | Global interrupt enable |
| pwm_out | output | 1 | PWM pin level |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The embedded properties assume that `tick`, `wr_en` and their companions are stable, known values at each rising edge. They also assume at most one register write per cycle, which the single write port enforces. The bench drives every input on the falling edge, so no edge races a change. It keeps the phase values small, so each measured phase fits inside the bench's own timeout. The write-versus-underflow collisions are provoked on purpose by writing during a tick, with a reload of zero, so that an underflow falls on every cycle.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

   typedef enum logic [2:0] {
      ADDR_CNT    = 3'd0,
      ADDR_RELOAD = 3'd1,
      ADDR_CTRL   = 3'd2,
      ADDR_PCLR   = 3'd3,
      ADDR_OUT    = 3'd4
   } pwmt_addr_e;

   typedef struct packed {
      logic       irq_en;
      logic [2:0] mode;
      logic       run;
   } pwmt_ctrl_t;

   localparam int         CTRL_W          = 5;
   localparam logic [2:0] MODE_PWM_TOGGLE = 3'b101;

endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter
   import pwmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [CNT_W-1:0] reload,
   output logic             uf
);

   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q;
   logic             count_en;

   assign count_en = tick & run & ~cnt_wr;
   assign uf       = count_en & (cnt_q == ZERO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= ZERO;
      else if (cnt_wr)
         cnt_q <= cnt_wdata;
      else if (uf)
         cnt_q <= reload;
      else if (count_en)
         cnt_q <= cnt_q - 1'b1;
   end

   // R2
   reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> (cnt_q == $past(reload)));

   // R2
   decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && !cnt_wr && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R3 R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!tick || !run) && !cnt_wr) |=> $stable(cnt_q));

   // R11
   wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(cnt_wdata)));

endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
   import pwmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             uf,
   output logic [CNT_W-1:0] reload_q,
   output pwmt_ctrl_t       ctrl_q,
   output logic             pwm_out
);

   logic rel_wr, ctl_wr, out_wr, toggle_now;

   assign rel_wr     = wr_en & (wr_addr == ADDR_RELOAD);
   assign ctl_wr     = wr_en & (wr_addr == ADDR_CTRL);
   assign out_wr     = wr_en & (wr_addr == ADDR_OUT);
   assign toggle_now = uf & (ctrl_q.mode == MODE_PWM_TOGGLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         ctrl_q   <= '0;
      end else begin
         if (rel_wr) reload_q <= wr_data;
         if (ctl_wr) ctrl_q   <= pwmt_ctrl_t'(wr_data[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pwm_out <= 1'b0;
      else if (out_wr)
         pwm_out <= wr_data[0];
      else if (toggle_now)
         pwm_out <= ~pwm_out;
   end

   // R5
   toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf && ctrl_q.mode == MODE_PWM_TOGGLE && !out_wr) |=> (pwm_out != $past(pwm_out)));

   // R5
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!uf || ctrl_q.mode != MODE_PWM_TOGGLE) && !out_wr) |=> $stable(pwm_out));

   // R10
   reload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rel_wr |=> $stable(reload_q));

endmodule

// File: rtl/pwmt_irq.sv
module pwmt_irq #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic uf,
   input  logic clr,
   input  logic irq_en,
   input  logic gie,
   output logic irq
);

   logic pend_q, req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (uf)
         pend_q <= 1'b1;
      else if (clr)
         pend_q <= 1'b0;
   end

   assign req = pend_q & irq_en & gie;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= req;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = req;
         // R8
         irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (pend_q && irq_en && gie));
      end
   endgenerate

   // R7
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> pend_q);

   // R9
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
   import pwmt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             gie,
   output logic             pwm_out,
   output logic             irq
);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("pwm_reload_timer: CNT_W must hold the control field");
      end
   endgenerate

   logic             uf, cnt_wr, pend_clr;
   logic [CNT_W-1:0] reload_q;
   pwmt_ctrl_t       ctrl_q;

   assign cnt_wr   = wr_en & (wr_addr == ADDR_CNT);
   assign pend_clr = wr_en & (wr_addr == ADDR_PCLR) & wr_data[0];

   pwmt_regs #(.CNT_W(CNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .uf       (uf),
      .reload_q (reload_q),
      .ctrl_q   (ctrl_q),
      .pwm_out  (pwm_out)
   );

   pwmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .run       (ctrl_q.run),
      .cnt_wr    (cnt_wr),
      .cnt_wdata (wr_data),
      .reload    (reload_q),
      .uf        (uf)
   );

   pwmt_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .uf     (uf),
      .clr    (pend_clr),
      .irq_en (ctrl_q.irq_en),
      .gie    (gie),
      .irq    (irq)
   );

   // R3
   no_uf_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.run |-> !uf);

endmodule

// File: tb/tb_pwm_reload_timer.sv
`timescale 1ns/1ps
module tb_pwm_reload_timer;

   localparam int CNT_W = 16;
   localparam logic [4:0] CTL_PWM_IE = 5'b11011;
   localparam int NVEC = 6;
   // {first, reload_a, reload_b, tick_gap, start_level}
   localparam logic [50:0] VEC [NVEC] = '{
      {16'd5,   16'd3,  16'd7,  2'd1, 1'b0},
      {16'd0,   16'd0,  16'd2,  2'd1, 1'b1},
      {16'd10,  16'd1,  16'd0,  2'd2, 1'b0},
      {16'd2,   16'd20, 16'd4,  2'd3, 1'b1},
      {16'd100, 16'd50, 16'd9,  2'd1, 1'b0},
      {16'd1,   16'd6,  16'd6,  2'd3, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, gie = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [CNT_W-1:0] wr_data = '0;
   logic pwm_out, irq;
   int n_vec = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_reload_timer #(.CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .gie(gie), .pwm_out(pwm_out), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input logic tk);
      @(negedge clk); tick = tk; wr_en = 1'b0;
      @(posedge clk); #1; tick = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d, input logic tk);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; tick = tk;
      @(posedge clk); #1; wr_en = 1'b0; tick = 1'b0;
   endtask

   task automatic measure(input int gap, output int n);
      int c = 0;
      logic prev = pwm_out;
      n = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk); tick = ((c % gap) == 0); c++;
         @(posedge clk); #1;
         if (tick) n++;
         if (pwm_out !== prev) begin tick = 1'b0; return; end
      end
      tick = 1'b0;
      n = -1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 pwm_out", int'(pwm_out), 0);
      chk("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      cyc(1'b1);
      chk("R1 idle after ticks", int'(pwm_out), 0);
      gie = 1'b1;

      // Vector table: R2 phase lengths, R10 deferred reload, R7/R8 irq
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] f, ra, rb;
         int gp;
         logic lv;
         {f, ra, rb} = VEC[v][50:3];
         gp = int'(VEC[v][2:1]);
         lv = VEC[v][0];
         wr(ADDR_CTRL_C, 16'd0, 1'b0);
         wr(3'd3, 16'd1, 1'b0);
         wr(3'd0, f, 1'b0);
         wr(3'd1, ra, 1'b0);
         wr(3'd4, {15'd0, lv}, 1'b0);
         chk("R6 latch level", int'(pwm_out), int'(lv));
         wr(ADDR_CTRL_C, {11'd0, CTL_PWM_IE}, 1'b0);
         measure(gp, n);
         chk("R2 first phase", n, int'(f) + 1);
         chk("R5 toggled", int'(pwm_out), int'(!lv));
         chk("R8 irq on edge", int'(irq), 1);
         wr(3'd1, rb, 1'b0);
         wr(3'd3, 16'd1, 1'b0);
         chk("R9 cleared", int'(irq), 0);
         measure(gp, n);
         chk("R10 old reload used", n, int'(ra) + 1);
         measure(gp, n);
         chk("R10 new reload used", n, int'(rb) + 1);
      end

      // R3: run clear holds
      wr(ADDR_CTRL_C, 16'd0, 1'b0);
      wr(3'd3, 16'd1, 1'b0);
      wr(3'd0, 16'd2, 1'b0);
      wr(3'd4, 16'd0, 1'b0);
      wr(ADDR_CTRL_C, 16'b11010, 1'b0);
      repeat (20) cyc(1'b1);
      chk("R3 no toggle while stopped", int'(pwm_out), 0);
      chk("R3 no pending while stopped", int'(irq), 0);
      // R4: run set, tick low
      wr(ADDR_CTRL_C, {11'd0, CTL_PWM_IE}, 1'b0);
      repeat (20) cyc(1'b0);
      chk("R4 no toggle without tick", int'(pwm_out), 0);
      measure(1, n);
      chk("R3 R4 count resumes from held value", n, 3);

      // R5 / R7: non-toggle mode sets pending, holds output
      wr(ADDR_CTRL_C, 16'd0, 1'b0);
      wr(3'd3, 16'd1, 1'b0);
      wr(3'd0, 16'd3, 1'b0);
      wr(3'd4, 16'd1, 1'b0);
      wr(ADDR_CTRL_C, 16'b10001, 1'b0);
      repeat (3) cyc(1'b1);
      chk("R7 no pending before underflow", int'(irq), 0);
      cyc(1'b1);
      chk("R7 pending at underflow", int'(irq), 1);
      chk("R5 other mode holds output", int'(pwm_out), 1);

      // R8 masking combinations, R9 enable write does not clear
      wr(ADDR_CTRL_C, 16'b00000, 1'b0);
      chk("R8 masked by enable", int'(irq), 0);
      gie = 1'b0;
      wr(ADDR_CTRL_C, 16'b10000, 1'b0);
      chk("R8 masked by gie", int'(irq), 0);
      gie = 1'b1;
      cyc(1'b0);
      chk("R9 enable write keeps pending", int'(irq), 1);
      wr(3'd3, 16'd0, 1'b0);
      chk("R9 clear with bit0=0 ignored", int'(irq), 1);
      wr(3'd3, 16'd1, 1'b0);
      chk("R9 clear works", int'(irq), 0);

      // R9: underflow wins over clear in the same cycle
      wr(3'd1, 16'd0, 1'b0);
      wr(3'd0, 16'd0, 1'b0);
      wr(ADDR_CTRL_C, 16'b10001, 1'b0);
      cyc(1'b1);
      chk("R9 pending set", int'(irq), 1);
      wr(3'd3, 16'd1, 1'b1);
      chk("R9 set wins over clear", int'(irq), 1);

      // R11: counter write overrides decrement while running
      wr(ADDR_CTRL_C, 16'd0, 1'b0);
      wr(3'd3, 16'd1, 1'b0);
      wr(3'd1, 16'd200, 1'b0);
      wr(3'd0, 16'd200, 1'b0);
      wr(3'd4, 16'd0, 1'b0);
      wr(ADDR_CTRL_C, {11'd0, CTL_PWM_IE}, 1'b0);
      repeat (5) cyc(1'b1);
      wr(3'd0, 16'd4, 1'b1);
      chk("R11 no underflow on write", int'(pwm_out), 0);
      measure(1, n);
      chk("R11 written value used", n, 5);
      // R11: write while counter at zero suppresses underflow
      wr(3'd0, 16'd0, 1'b0);
      wr(3'd3, 16'd1, 1'b0);
      wr(3'd0, 16'd3, 1'b1);
      chk("R11 write masks zero underflow", int'(irq), 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   localparam logic [2:0] ADDR_CTRL_C = 3'd2;

endmodule